// File: doc/BRIEF.md
# Two-Range Programmable Interval Timer

This block raises an interrupt once a programmed delay has elapsed. The delay is set in a single 8-bit control byte. A three-bit coarse field counts steps of 2.048 s, and a five-bit fine field adds a term of (fine+1) × 64 ms. The block does not measure time itself. It counts pulses on a tick-enable input, and each pulse stands for 64 ms, so one coarse step is 32 ticks.

The host loads the control byte through a one-cycle write strobe and launches the count with a separate start strobe. Coarse codes 0 to 6 give a single interrupt after `coarse*32 + fine + 1` ticks. The all-ones coarse code selects periodic operation: an interrupt follows every `fine + 1` ticks until the host stops the timer. Writing the control byte stops the timer in either mode. A busy output shows whether the timer is counting. There is no streaming data path, so every pin is a plain control or status signal with no back-pressure.

Top module: `tmr_interval`

## Requirements
- R1: After reset the control byte is 0x00, busy is 0 and irq is 0. Starting the timer without any write therefore expires after exactly 1 tick.
- R2: The coarse field sits in control bits 7:5 and the fine field in bits 4:0. For coarse values 0 to 6, irq is raised on the clock edge that samples tick number `coarse*32 + fine + 1` after the start, and on no earlier one.
- R3: With coarse = 7, irq is raised on every `fine + 1`-th tick after the start, indefinitely, and busy stays 1 throughout.
- R4: A register write alone never starts the timer. Ticks arriving after a write and without a start produce no irq and leave busy at 0.
- R5: In single-shot mode the timer stops on the expiry edge. Busy is 0 in the cycle that shows irq, and later ticks give no further irq.
- R6: A register write stops a running timer in either mode. From the next cycle busy is 0, and no irq follows until a new start.
- R7: A start strobe while the timer is running restarts the tick count from zero with the current control byte.
- R8: When a write and a start occur in the same cycle, the write wins. The timer stays stopped and busy is 0.
- R9: irq is a pulse lasting a single clock cycle, asserted in the cycle after the clock edge that sampled the terminal tick. Busy is 1 from the cycle after a start until the timer stops.
- R10: Ticks are ignored while the timer is stopped, and cycles with tick low do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the control byte |
| cfg_data | input | 8 | Control byte: coarse in [7:5], fine in [4:0] |
| start | input | 1 | Start/restart command strobe |
| tick | input | 1 | 64 ms tick enable, one cycle wide |
| busy | output | 1 | Timer is counting |
| irq | output | 1 | One-cycle expiry pulse |

## Verification
Two pairs of actions can fall in the same cycle. One pair is a control write and a start. The bench drives both strobes on one edge and judges the result by busy staying low and by a following run of ticks producing no irq. The other pair is a start and the ticks of a count already in progress. The bench issues a second start partway through a count and checks that the first irq arrives a full terminal count after that restart, not after the original start.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned COARSE_W = 3;
  localparam int unsigned FINE_W   = 5;
  localparam int unsigned CFG_W    = COARSE_W + FINE_W;
  localparam int unsigned LIM_W    = CFG_W + 1;

  typedef struct packed {
    logic [COARSE_W-1:0] coarse;
    logic [FINE_W-1:0]   fine;
  } tmr_cfg_t;
endpackage

// File: rtl/tmr_cfg_reg.sv
module tmr_cfg_reg
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output tmr_cfg_t         cfg
);
  always_ff @(posedge clk) begin
    if (!rst_n)  cfg <= '0;
    else if (wr) cfg <= tmr_cfg_t'(wdata);
  end

  // R1: the register comes out of reset cleared
  a_r1_cfg_reset: assert property (@(posedge clk) !rst_n |=> cfg == '0);
endmodule

// File: rtl/tmr_limit.sv
module tmr_limit
  import tmr_pkg::*;
(
  input  tmr_cfg_t         cfg,
  output logic [LIM_W-1:0] limit,
  output logic             periodic
);
  localparam int unsigned COARSE_TICKS = 1 << FINE_W;

  logic [LIM_W-1:0] fine_ticks;
  logic [LIM_W-1:0] coarse_ticks;

  assign periodic     = &cfg.coarse;
  assign fine_ticks   = LIM_W'(cfg.fine) + LIM_W'(1);
  assign coarse_ticks = LIM_W'(cfg.coarse) * LIM_W'(COARSE_TICKS);
  assign limit        = periodic ? fine_ticks : coarse_ticks + fine_ticks;

  always_comb begin
    // R2: the terminal count is never zero
    a_r2_limit_nonzero: assert (limit != '0);
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic             tick,
  input  logic [LIM_W-1:0] limit,
  input  logic             periodic,
  output logic             running,
  output logic             irq
);
  logic [LIM_W-1:0] cnt;
  logic [LIM_W-1:0] cnt_nxt;

  assign cnt_nxt = cnt + LIM_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (clr) begin
        running <= 1'b0;
        cnt     <= '0;
      end else if (start) begin
        running <= 1'b1;
        cnt     <= '0;
      end else if (running && tick) begin
        if (cnt_nxt == limit) begin
          irq     <= 1'b1;
          cnt     <= '0;
          running <= periodic;
        end else begin
          cnt <= cnt_nxt;
        end
      end
    end
  end

  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> cnt < limit);
  a_r10_irq_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tick) && $past(running));
  a_r5_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !periodic |-> !running);
  a_r3_periodic_continues: assert property (@(posedge clk) disable iff (!rst_n)
    irq && periodic |-> running);
  a_r6_clear_stops: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !running && !irq);
  a_r4_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    start && !clr |=> running && !irq);
endmodule

// File: rtl/tmr_interval.sv
module tmr_interval
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             start,
  input  logic             tick,
  output logic             busy,
  output logic             irq
);
  tmr_cfg_t         cfg;
  logic [LIM_W-1:0] limit;
  logic             periodic;

  tmr_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .wdata (cfg_data),
    .cfg   (cfg)
  );

  tmr_limit u_lim (
    .cfg      (cfg),
    .limit    (limit),
    .periodic (periodic)
  );

  tmr_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cfg_wr),
    .start    (start),
    .tick     (tick),
    .limit    (limit),
    .periodic (periodic),
    .running  (busy),
    .irq      (irq)
  );

  // R8: a write beats a simultaneous start
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && start |=> !busy);
  // R9: an idle timer emits nothing
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$past(busy) |-> !irq);
endmodule

// File: tb/tmr_interval_tb.sv
module tmr_interval_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_data = '0;
  logic       start = 1'b0;
  logic       tick = 1'b0;
  logic       busy;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  tmr_interval u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .start(start), .tick(tick), .busy(busy), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] c, input logic [4:0] f);
    @(negedge clk); cfg_wr = 1'b1; cfg_data = {c, f};
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic go();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // n back-to-back ticks; reports the tick index of the first irq and the irq total
  task automatic ticks(input int n, output int first, output int cnt);
    first = 0; cnt = 0;
    for (int i = 1; i <= n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      if (irq) begin
        cnt++;
        if (first == 0) first = i;
      end
    end
    tick = 1'b0;
  endtask

  task automatic t_reset();
    int f, c;
    chk("R1 busy after reset", busy, 0);
    chk("R1 irq after reset", irq, 0);
    go();
    chk("R9 busy after start", busy, 1);
    ticks(1, f, c);
    chk("R1 default expiry tick", f, 1);
    chk("R5 busy at expiry", busy, 0);
    @(negedge clk);
    chk("R9 irq lasts one cycle", irq, 0);
  endtask

  task automatic t_oneshot();
    int f, c;
    wr(3'd1, 5'd3);
    go();
    ticks(35, f, c);
    chk("R2 no early irq (1,3)", c, 0);
    chk("R9 busy while counting", busy, 1);
    ticks(1, f, c);
    chk("R2 irq on tick 36", c, 1);
    chk("R5 busy cleared", busy, 0);
    ticks(40, f, c);
    chk("R5 no later irq", c, 0);
    wr(3'd2, 5'd31);
    go();
    ticks(100, f, c);
    chk("R2 expiry tick (2,31)", f, 96);
    chk("R2 single irq (2,31)", c, 1);
    wr(3'd6, 5'd0);
    go();
    ticks(200, f, c);
    chk("R2 expiry tick (6,0)", f, 193);
  endtask

  task automatic t_no_autostart();
    int f, c;
    wr(3'd0, 5'd0);
    chk("R4 busy after write", busy, 0);
    ticks(10, f, c);
    chk("R4 no irq without start", c, 0);
  endtask

  task automatic t_periodic();
    int f, c;
    wr(3'd7, 5'd2);
    go();
    ticks(9, f, c);
    chk("R3 first periodic irq", f, 3);
    chk("R3 periodic irq count", c, 3);
    chk("R3 busy stays high", busy, 1);
    wr(3'd7, 5'd2);
    chk("R6 busy cleared by write", busy, 0);
    ticks(12, f, c);
    chk("R6 no irq after write", c, 0);
  endtask

  task automatic t_restart();
    int f, c;
    wr(3'd0, 5'd4);
    go();
    ticks(3, f, c);
    go();
    ticks(4, f, c);
    chk("R7 no irq before restarted limit", c, 0);
    ticks(1, f, c);
    chk("R7 irq after full restarted count", c, 1);
  endtask

  task automatic t_write_start();
    int f, c;
    @(negedge clk); cfg_wr = 1'b1; start = 1'b1; cfg_data = 8'h00;
    @(negedge clk); cfg_wr = 1'b0; start = 1'b0;
    chk("R8 busy after write+start", busy, 0);
    ticks(5, f, c);
    chk("R8 no irq after write+start", c, 0);
  endtask

  task automatic t_idle_ticks();
    int f, c;
    wr(3'd0, 5'd5);
    ticks(20, f, c);
    go();
    repeat (10) @(negedge clk);
    chk("R10 no irq without ticks", irq, 0);
    ticks(10, f, c);
    chk("R10 expiry counts only ticks", f, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_oneshot();
    t_no_autostart();
    t_periodic();
    t_restart();
    t_write_start();
    t_idle_ticks();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule